// File: doc/BRIEF.md
# Absmean Ternary Weight Quantizer

This block turns one tensor of signed fixed-point weights into ternary codes, each of which is -1, 0 or +1. The weights stream in twice over a valid/ready input. In the first pass the block adds up the magnitudes of all weights. That sum gives one scale for the whole tensor, the mean absolute value. In the second pass the block divides each weight by the scale, rounds it to the nearest integer (ties away from zero) and clips it to -1..+1. It then emits the result as a 2-bit code.

The rounding needs no divider. A weight maps to a nonzero code exactly when twice its magnitude reaches the mean. The block tests this as `2·N·|W| ≥ S`, where S is the exact magnitude sum and N is the tensor size. The codes are packed sixteen to a 32-bit word and leave through a valid/ready output. The truncated mean is presented as a scale so that a later stage can dequantize. A single pulse marks the end of each tensor, after which the block waits for the next first pass.

Top module: `tq_quantizer`

## Requirements
- R1: The first pass accepts exactly N_WEIGHTS weights with `in_ready` held high, and no output word is offered during it.
- R2: From the cycle after the last first-pass weight is accepted, `scale` equals floor(S / N_WEIGHTS), where S is the sum of |W| over the tensor. It stays unchanged until the first weight of the next tensor is accepted. It is 0 out of reset.
- R3: Each second-pass weight W gets code 2'b00 (zero) when W = 0 or when 2·N_WEIGHTS·|W| < S. Otherwise it gets 2'b01 (+1) when W > 0 and 2'b11 (-1) when W < 0. Code 2'b10 never appears in an output word.
- R4: A tensor of all-zero weights gives scale 0 and all-zero output words.
- R5: Weight k of the second pass sits in bits [2·(k mod 16)+1 : 2·(k mod 16)] of output word floor(k/16). Words leave in order, and there are ceil(N_WEIGHTS/16) of them.
- R6: In a partly filled final word, the slots past the last weight are zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays stable. No second-pass weight is accepted while a word is pending.
- R8: `done` is high for exactly one cycle, the cycle after the last word is accepted. From then on `in_ready` is high for the next tensor's first pass.
- R9: The most negative input value (magnitude 2^(W_BITS-1)) is handled at full magnitude in both the sum and the code decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Weight present on `in_weight` |
| in_ready | output | 1 | Block takes the weight this cycle |
| in_weight | input | W_BITS | Signed weight |
| out_valid | output | 1 | Packed word present on `out_word` |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 2·CODES_PER_WORD | Packed ternary codes, earliest in the LSBs |
| scale | output | W_BITS | Truncated mean absolute value of the tensor |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The assertions watch the properties that hold on every cycle. No output is offered in the first pass. A pending word is held under backpressure, and nothing is pushed while a word waits. The illegal code never shows in a valid word. The magnitude sum never wraps. The scale holds between tensors, and `done` never lasts two cycles. Whether each code is right for its weight, whether the slots and the padding land in the right places, and whether the scale and the single end pulse come out right are shown only by the bench's scenarios. These scenarios include exact rounding ties, all-zero and all-minimum tensors, and random tensors under random backpressure.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    TQ_ZERO = 2'b00,
    TQ_POS  = 2'b01,
    TQ_NEG  = 2'b11
  } tcode_t;

  typedef enum logic [1:0] {
    ST_SUM   = 2'b00,
    ST_CODE  = 2'b01,
    ST_FLUSH = 2'b10
  } phase_t;
endpackage

// File: rtl/tq_abs_accum.sv
module tq_abs_accum #(
  parameter int W_BITS = 8,
  parameter int SUM_W  = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     first,
  input  logic signed [W_BITS-1:0] w,
  output logic [SUM_W-1:0]         sum
);
  logic [W_BITS-1:0] mag;
  logic [SUM_W-1:0]  sum_d, sum_q;

  // magnitude kept unsigned so the most negative value keeps full size (R9)
  assign mag = w[W_BITS-1] ? W_BITS'(-w) : W_BITS'(w);

  always_comb begin
    sum_d = sum_q;
    if (en) begin
      sum_d = first ? SUM_W'(mag) : sum_q + SUM_W'(mag);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;

  assert_sum_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/tq_encoder.sv
module tq_encoder #(
  parameter int W_BITS    = 8,
  parameter int N_WEIGHTS = 40,
  parameter int SUM_W     = 14
) (
  input  logic signed [W_BITS-1:0] w,
  input  logic [SUM_W-1:0]         sum,
  output tq_pkg::tcode_t           code
);
  import tq_pkg::*;
  localparam int PROD_W = SUM_W + 1;

  logic [W_BITS-1:0] mag;
  logic [PROD_W-1:0] lhs;
  logic              keep;

  assign mag  = w[W_BITS-1] ? W_BITS'(-w) : W_BITS'(w);
  // |W|/mean >= 1/2  <=>  2*N*|W| >= S ; no divide needed
  assign lhs  = PROD_W'(mag) * PROD_W'(2 * N_WEIGHTS);
  assign keep = (mag != '0) && (lhs >= PROD_W'(sum));

  always_comb begin
    code = TQ_ZERO;
    if (keep) code = w[W_BITS-1] ? TQ_NEG : TQ_POS;
  end
endmodule

// File: rtl/tq_packer.sv
module tq_packer #(
  parameter int CODES_PER_WORD = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  tq_pkg::tcode_t              code,
  input  logic                        last,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [2*CODES_PER_WORD-1:0] out_word
);
  localparam int WORD_BITS = 2 * CODES_PER_WORD;
  localparam int SLOT_W    = $clog2(CODES_PER_WORD);
  localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(CODES_PER_WORD - 1);

  logic [WORD_BITS-1:0] acc_q, acc_d, word_q, word_d, merged;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic                 vld_q, vld_d;

  assign merged = acc_q | (WORD_BITS'(code) << {slot_q, 1'b0});

  always_comb begin
    acc_d  = acc_q;
    slot_d = slot_q;
    word_d = word_q;
    vld_d  = vld_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (push) begin
      if (last || slot_q == TOP_SLOT) begin
        word_d = merged;
        vld_d  = 1'b1;
        acc_d  = '0;
        slot_d = '0;
      end else begin
        acc_d  = merged;
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      slot_q <= slot_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;

  logic bad_code;
  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < CODES_PER_WORD; i++) begin
      if (word_q[2*i +: 2] == 2'b10) bad_code = 1'b1;
    end
  end

  assert_no_illegal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !bad_code);
  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(word_q)));
  assert_push_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !vld_q);
endmodule

// File: rtl/tq_quantizer.sv
module tq_quantizer #(
  parameter int W_BITS         = 8,
  parameter int N_WEIGHTS      = 40,
  parameter int CODES_PER_WORD = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic signed [W_BITS-1:0]    in_weight,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [2*CODES_PER_WORD-1:0] out_word,
  output logic [W_BITS-1:0]           scale,
  output logic                        done
);
  import tq_pkg::*;
  localparam int SUM_W = W_BITS + $clog2(N_WEIGHTS + 1);
  localparam int CNT_W = $clog2(N_WEIGHTS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_WEIGHTS - 1);

  // reset: asserted asynchronously, released through two flops
  logic rs_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s   <= rs_meta;
    end
  end

  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             fire, acc_en, acc_first, push, last;
  logic [SUM_W-1:0] sum;
  tcode_t           code;

  assign in_ready = (st_q == ST_SUM) || (st_q == ST_CODE && !out_valid);
  assign fire     = in_valid && in_ready;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    acc_en    = 1'b0;
    acc_first = 1'b0;
    push      = 1'b0;
    last      = 1'b0;
    case (st_q)
      ST_SUM: if (fire) begin
        acc_en    = 1'b1;
        acc_first = (cnt_q == '0);
        if (cnt_q == LAST_IDX) begin
          cnt_d = '0;
          st_d  = ST_CODE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CODE: if (fire) begin
        push = 1'b1;
        if (cnt_q == LAST_IDX) begin
          last  = 1'b1;
          cnt_d = '0;
          st_d  = ST_FLUSH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FLUSH: if (out_valid && out_ready) begin
        done_d = 1'b1;
        st_d   = ST_SUM;
      end
      default: st_d = ST_SUM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_SUM;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  tq_abs_accum #(.W_BITS(W_BITS), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_s), .en(acc_en), .first(acc_first),
    .w(in_weight), .sum(sum)
  );

  tq_encoder #(.W_BITS(W_BITS), .N_WEIGHTS(N_WEIGHTS), .SUM_W(SUM_W)) u_enc (
    .w(in_weight), .sum(sum), .code(code)
  );

  tq_packer #(.CODES_PER_WORD(CODES_PER_WORD)) u_pack (
    .clk(clk), .rst_n(rst_s), .push(push), .code(code), .last(last),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );

  assign scale = W_BITS'(sum / SUM_W'(N_WEIGHTS));
  assign done  = done_q;

  assert_quiet_in_sum_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_SUM) |-> !out_valid);
  assert_scale_held_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !(st_q == ST_SUM && fire) |=> $stable(scale));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q);
endmodule

// File: tb/tq_quantizer_bench.sv
`timescale 1ns/1ps
module tq_quantizer_bench;
  localparam int WB  = 8;
  localparam int NW  = 40;
  localparam int CPW = 16;
  localparam int NWORDS = (NW + CPW - 1) / CPW;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, done;
  logic signed [WB-1:0] in_weight;
  logic [2*CPW-1:0] out_word;
  logic [WB-1:0] scale;

  always #2.5 clk = ~clk;

  tq_quantizer #(.W_BITS(WB), .N_WEIGHTS(NW), .CODES_PER_WORD(CPW)) u_tq_quantizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_weight(in_weight), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .scale(scale), .done(done)
  );

  int tests = 0, fails = 0, cyc = 0;
  int wts[NW];
  logic [2*CPW-1:0] got[$];
  int last_hs = -1, done_cyc = -1, done_cnt = 0;
  bit rdy_rand = 1'b0;
  bit pend = 1'b0;
  logic [2*CPW-1:0] pend_word;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_sum();
    int s = 0;
    for (int i = 0; i < NW; i++) s += (wts[i] < 0) ? -wts[i] : wts[i];
    return s;
  endfunction

  function automatic int exp_code(input int w, input int s);
    int m = (w < 0) ? -w : w;
    if (w == 0) return 0;
    if (2 * NW * m >= s) return (w > 0) ? 1 : 3;
    return 0;
  endfunction

  function automatic logic [2*CPW-1:0] exp_word(input int k, input int s);
    logic [2*CPW-1:0] r = '0;
    for (int j = 0; j < CPW; j++) begin
      if (k * CPW + j < NW) r |= (2*CPW)'(exp_code(wts[k*CPW+j], s)) << (2*j);
    end
    return r;
  endfunction

  // consumer and monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (pend) chk(out_valid && out_word == pend_word, "R7", "word held under backpressure",
                    out_word, pend_word);
      out_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
      pend = out_valid && !out_ready;
      pend_word = out_word;
      if (out_valid && out_ready) begin
        got.push_back(out_word);
        last_hs = cyc + 1;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic send(input int w);
    in_valid = 1'b1;
    in_weight = WB'(w);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_tensor(input string name, input bit rnd);
    int s, t;
    got.delete();
    done_cnt = 0;
    rdy_rand = rnd;
    s = exp_sum();
    for (int i = 0; i < NW; i++) send(wts[i]);
    in_valid = 1'b0;
    chk(!out_valid && got.size() == 0, "R1", {name, " no output in first pass"}, got.size(), 0);
    chk(scale == WB'(s / NW), "R2", {name, " scale after first pass"}, scale, s / NW);
    for (int i = 0; i < NW; i++) send(wts[i]);
    in_valid = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 1000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R8", {name, " single done pulse"}, done_cnt, 1);
    chk(done_cyc == last_hs, "R8", {name, " done one cycle after last word"}, done_cyc, last_hs);
    chk(in_ready, "R8", {name, " ready for next tensor"}, in_ready, 1);
    chk(got.size() == NWORDS, "R5", {name, " word count"}, got.size(), NWORDS);
    for (int k = 0; k < NWORDS && k < got.size(); k++) begin
      chk(got[k] == exp_word(k, s), (k == NWORDS - 1) ? "R6" : "R5",
          {name, " packed word (R3 codes)"}, got[k], exp_word(k, s));
    end
    chk(scale == WB'(s / NW), "R2", {name, " scale held"}, scale, s / NW);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    in_valid = 1'b0;
    in_weight = '0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !done, "R1", "reset handshake state", in_ready, 1);
    chk(scale == 0, "R2", "reset scale", scale, 0);

    // R4: all zero
    for (int i = 0; i < NW; i++) wts[i] = 0;
    run_tensor("zero", 1'b0);

    // R3: exact tie and just below, S = 800
    wts[0] = 10; wts[1] = -9; wts[2] = -41;
    for (int i = 3; i < NW; i++) wts[i] = (i % 2) ? 20 : -20;
    run_tensor("tie", 1'b1);

    // R9: all most-negative
    for (int i = 0; i < NW; i++) wts[i] = -128;
    run_tensor("minval", 1'b1);

    // R9 mixed in a small-valued tensor
    for (int i = 0; i < NW; i++) wts[i] = int'($urandom_range(0, 6)) - 3;
    wts[7] = -128;
    run_tensor("minmix", 1'b0);

    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NW; i++) wts[i] = int'($urandom_range(0, 255)) - 128;
      run_tensor("rand_wide", 1'b1);
    end
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NW; i++) wts[i] = int'($urandom_range(0, 8)) - 4;
      run_tensor("rand_narrow", 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule